// File: doc/BRIEF.md
# Cascadable Serial Control Port

This block is the device-side end of a 16-bit serial control link. A controller drives a serial clock, a data line and a per-transfer select. Each device shifts bits into a private shift register while its select is high. When the select drops, the register contents are copied in one step into a parallel control word, and a one-cycle write strobe is raised. Whatever logic consumes the word decodes its fields; this block does not.

Two cascade arrangements are supported, and a static mode pin chooses between them. In chain mode, each device's serial output feeds the next device's serial input. Every device shares the clock and the select, so N devices behave as a single 16*N-bit shift register, and the controller pushes the word meant for the farthest device first. In bus mode, all devices share the data-in and data-out wires. Each device has its own select, and a device drives its output only while it is selected; the output enable is a separate pin so the board can resolve the shared wire.

The serial pins are treated as synchronous to `clk` and slow compared with it: each serial clock phase lasts at least two `clk` cycles. Edges are found by comparing each pin with its value one `clk` earlier.

Top module: `scp_ctrl_port`

## Requirements
- R1: Reset (synchronous, active high) clears the shift register, `ctrl_word`, `wr_strobe` and `sdout` to zero.
- R2: On each `clk` edge that detects a rising `sclk` while `sel` is high, `sdin` enters the shift register at bit 0 and every other bit moves up one place. The first bit sent therefore ends up in bit 15, so transfers are MSB first.
- R3: `sdout` changes only on a `clk` edge that detects a falling `sclk` while `sel` is high, and it then takes bit 15 of the shift register. A reader that samples just before each rising `sclk` therefore receives the previous register contents MSB first.
- R4: On the first `clk` edge at which `sel` is seen low after being high, `ctrl_word` loads the full shift register. At that same edge `wr_strobe` goes high, and it stays high for exactly one cycle.
- R5: While `sel` is low, `sclk` and `sdin` are ignored in both modes: the shift register and `sdout` keep their values.
- R6: In bus mode (`bus_mode` = 1), `sdout_oe` is high exactly while `sel` is high.
- R7: In chain mode (`bus_mode` = 0), `sdout_oe` is always high.
- R8: In a chain of N devices that share `sclk` and `sel`, the select stays high for 16*N rising clocks and the controller sends the farthest device's word first. At the end, each device's `ctrl_word` holds its own word. During that transfer, the last device's `sdout` returns the previous contents of the chain, farthest device first.
- R9: In bus mode, the selected device's `sdout` returns the word it previously held, MSB first, during the next transfer to that device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Static cascade mode: 0 chain, 1 shared bus |
| sel | input | 1 | Transfer select, active high |
| sclk | input | 1 | Serial control clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Drive enable for `sdout` |
| ctrl_word | output | W | Last captured control word |
| wr_strobe | output | 1 | One-cycle pulse when `ctrl_word` is updated |

## Verification
A shift happens at the first `clk` edge that sees the new `sclk` level, and `sdout` moves at the first edge after a falling `sclk`. The bench therefore holds each serial phase for four `clk` cycles and reads `sdout` only while `sclk` is low, just before raising it. The control word and strobe are due exactly one `clk` edge after `sel` drops. Each scoreboard entry records that target cycle, and the monitor compares the entry with the cycle in which it actually sees the strobe, sampling on falling `clk`. Because the bench drives the select-low window with idle serial toggles and then an empty select, the monitor sees the old word come back. This shows that the register was left untouched.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int WORD_W = 16;

    typedef enum logic {
        CASC_CHAIN = 1'b0,
        CASC_BUS   = 1'b1
    } casc_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic logic oe_for_mode(casc_mode_e m, logic selected);
        return (m == CASC_BUS) ? selected : 1'b1;
    endfunction

endpackage

// File: rtl/scp_edge_det.sv
module scp_edge_det #(
    parameter int N = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N-1:0]                    pin,
    output scp_pkg::pin_evt_t [N-1:0]       evt
);
    logic [N-1:0] pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign evt[i] = '{rise: pin[i] & ~pin_q[i], fall: ~pin[i] & pin_q[i]};
    end
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
    parameter int W = scp_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdin,
    input  logic         load_en,
    output logic [W-1:0] shreg,
    output logic [W-1:0] ctrl_word,
    output logic         wr_strobe
);
    always_ff @(posedge clk) begin
        if (rst)           shreg <= '0;
        else if (shift_en) shreg <= {shreg[W-2:0], sdin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= '0;
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= load_en;
            if (load_en) ctrl_word <= shreg;
        end
    end
endmodule

// File: rtl/scp_out_stage.sv
module scp_out_stage (
    input  logic                clk,
    input  logic                rst,
    input  scp_pkg::casc_mode_e mode,
    input  logic                sel,
    input  logic                fall_en,
    input  logic                msb,
    output logic                sdout,
    output logic                sdout_oe
);
    always_ff @(posedge clk) begin
        if (rst)          sdout <= 1'b0;
        else if (fall_en) sdout <= msb;
    end

    assign sdout_oe = scp_pkg::oe_for_mode(mode, sel);
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port #(
    parameter int W = scp_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_mode,
    input  logic         sel,
    input  logic         sclk,
    input  logic         sdin,
    output logic         sdout,
    output logic         sdout_oe,
    output logic [W-1:0] ctrl_word,
    output logic         wr_strobe
);
    import scp_pkg::*;

    localparam int PIN_SCLK = 0;
    localparam int PIN_SEL  = 1;
    localparam int NPINS    = 2;

    casc_mode_e              mode_e;
    pin_evt_t [NPINS-1:0]    evt;
    logic [W-1:0]            shreg;
    logic                    shift_en;
    logic                    fall_en;
    logic                    load_en;
    logic                    sel_rise_unused;

    assign mode_e = casc_mode_e'(bus_mode);

    scp_edge_det #(.N(NPINS)) u_edges (
        .clk (clk),
        .rst (rst),
        .pin ({sel, sclk}),
        .evt (evt)
    );

    assign shift_en        = evt[PIN_SCLK].rise & sel;
    assign fall_en         = evt[PIN_SCLK].fall & sel;
    assign load_en         = evt[PIN_SEL].fall;
    assign sel_rise_unused = evt[PIN_SEL].rise;

    scp_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .sdin      (sdin),
        .load_en   (load_en),
        .shreg     (shreg),
        .ctrl_word (ctrl_word),
        .wr_strobe (wr_strobe)
    );

    scp_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .sel      (sel),
        .fall_en  (fall_en),
        .msb      (shreg[W-1]),
        .sdout    (sdout),
        .sdout_oe (sdout_oe)
    );
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         sel,
    input logic         sclk,
    input logic         sdin,
    input logic         sdout,
    input logic         wr_strobe,
    input logic [W-1:0] ctrl_word,
    input logic [W-1:0] shreg
);
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && sel) |=> (shreg == {$past(shreg[W-2:0]), $past(sdin)}));

    p_out_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        !($fell(sclk) && sel) |=> $stable(sdout));

    p_release_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sel) |=> wr_strobe);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    p_load_word_r4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (ctrl_word == $past(shreg)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(shreg));
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .sclk      (sclk),
    .sdin      (sdin),
    .sdout     (sdout),
    .wr_strobe (wr_strobe),
    .ctrl_word (ctrl_word),
    .shreg     (shreg)
);

// File: tb/tb_scp_ctrl_port.sv
module tb_scp_ctrl_port;
    localparam int N = 3;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int fails = 0;

    // chain group
    logic ch_sclk = 0, ch_sel = 0, ch_sdin = 0;
    logic [N-1:0] ch_dout, ch_oe, ch_stb;
    logic [N-1:0][W-1:0] ch_word;
    // bus group
    logic bus_sclk = 0, bus_sdin = 0;
    logic [N-1:0] bus_sel = '0;
    logic [N-1:0] bus_dout, bus_oe, bus_stb;
    logic [N-1:0][W-1:0] bus_word;
    logic bus_line;
    assign bus_line = |(bus_dout & bus_oe);

    for (genvar g = 0; g < N; g++) begin : g_chain
        scp_ctrl_port #(.W(W)) dut (
            .clk(clk), .rst(rst), .bus_mode(1'b0), .sel(ch_sel), .sclk(ch_sclk),
            .sdin((g == 0) ? ch_sdin : ch_dout[(g == 0) ? 0 : g - 1]),
            .sdout(ch_dout[g]), .sdout_oe(ch_oe[g]),
            .ctrl_word(ch_word[g]), .wr_strobe(ch_stb[g]));
    end

    for (genvar g = 0; g < N; g++) begin : g_bus
        scp_ctrl_port #(.W(W)) dut (
            .clk(clk), .rst(rst), .bus_mode(1'b1), .sel(bus_sel[g]), .sclk(bus_sclk),
            .sdin(bus_sdin), .sdout(bus_dout[g]), .sdout_oe(bus_oe[g]),
            .ctrl_word(bus_word[g]), .wr_strobe(bus_stb[g]));
    end

    typedef struct {
        int          dev;
        logic [W-1:0] word;
        int          due;
        string       req;
    } sb_item_t;
    sb_item_t sb[$];

    logic [N-1:0][W-1:0] ch_model = '0;
    logic [N-1:0][W-1:0] bus_model = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: devices 0..N-1 chain, N..2N-1 bus
    always @(negedge clk) begin
        if (!rst) begin
            for (int d = 0; d < 2 * N; d++) begin
                logic stb;
                logic [W-1:0] w;
                stb = (d < N) ? ch_stb[d] : bus_stb[d - N];
                w   = (d < N) ? ch_word[d] : bus_word[d - N];
                if (stb) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R4 unexpected strobe", d, 64'hFFFF);
                    end else begin
                        sb_item_t it;
                        it = sb.pop_front();
                        check(it.dev == d, {it.req, " strobe device"}, d, it.dev);
                        check(w == it.word, {it.req, " word"}, w, it.word);
                        check(cyc == it.due, "R4 strobe cycle", cyc, it.due);
                    end
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic serial_bit(input bit on_bus, input logic b, output logic rd);
        if (on_bus) bus_sdin = b; else ch_sdin = b;
        wait_clk(4);
        rd = on_bus ? bus_line : ch_dout[N-1];
        if (on_bus) bus_sclk = 1; else ch_sclk = 1;
        wait_clk(4);
        if (on_bus) bus_sclk = 0; else ch_sclk = 0;
    endtask

    task automatic chain_write(input logic [N-1:0][W-1:0] w, output logic [N*W-1:0] rd);
        logic [N*W-1:0] stream;
        for (int d = 0; d < N; d++) stream[d*W +: W] = w[d];
        ch_sel = 1;
        wait_clk(2);
        for (int i = N*W - 1; i >= 0; i--) begin
            logic r;
            serial_bit(1'b0, stream[i], r);
            rd[i] = r;
        end
        wait_clk(4);
        for (int d = 0; d < N; d++) sb.push_back('{d, w[d], cyc + 1, "R8"});
        ch_sel = 0;
        wait_clk(4);
    endtask

    task automatic bus_write(input int k, input logic [W-1:0] w, output logic [W-1:0] rd);
        bus_sel[k] = 1;
        wait_clk(2);
        check(bus_oe == N'(1 << k), "R6 oe while selected", bus_oe, N'(1 << k));
        for (int i = W - 1; i >= 0; i--) begin
            logic r;
            serial_bit(1'b1, w[i], r);
            rd[i] = r;
        end
        wait_clk(4);
        sb.push_back('{N + k, w, cyc + 1, "R2"});
        bus_sel[k] = 0;
        wait_clk(4);
        check(bus_oe == '0, "R6 oe released", bus_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [N*W-1:0] crd;
        logic [W-1:0] brd;
        logic [N-1:0][W-1:0] wv;
        logic [N-1:0] held;

        wait_clk(5);
        rst = 0;
        wait_clk(1);
        // R1 reset state
        check(ch_word == '0 && bus_word == '0, "R1 ctrl_word", {ch_word, bus_word}, 0);
        check(ch_stb == '0 && bus_stb == '0, "R1 strobe", {ch_stb, bus_stb}, 0);
        check(ch_dout == '0 && bus_dout == '0, "R1 sdout", {ch_dout, bus_dout}, 0);
        check(ch_oe == '1, "R7 chain oe", ch_oe, 3'b111);
        check(bus_oe == '0, "R6 bus oe idle", bus_oe, 0);

        // R8 first chain write
        wv[0] = 16'hA5C3; wv[1] = 16'h1234; wv[2] = 16'hFFFF;
        chain_write(wv, crd);
        check(crd == '0, "R8 readback after reset", crd, 0);
        ch_model = wv;
        check(ch_oe == '1, "R7 chain oe after write", ch_oe, 3'b111);

        // R8 second chain write, readback of prior contents farthest first
        wv[0] = 16'h8001; wv[1] = 16'h0000; wv[2] = 16'h7E5A;
        chain_write(wv, crd);
        check(crd == {ch_model[2], ch_model[1], ch_model[0]}, "R8 readback",
              crd, {ch_model[2], ch_model[1], ch_model[0]});
        ch_model = wv;

        // R5 chain: toggling with select low changes nothing
        held = ch_dout;
        for (int i = 0; i < W; i++) begin
            logic r;
            serial_bit(1'b0, i[0], r);
        end
        check(ch_dout == held, "R5 chain sdout held", ch_dout, held);
        ch_sel = 1;
        wait_clk(3);
        for (int d = 0; d < N; d++) sb.push_back('{d, ch_model[d], cyc + 1, "R5"});
        ch_sel = 0;
        wait_clk(4);

        // R2/R6 bus writes
        bus_write(0, 16'hBEEF, brd);
        check(brd == '0, "R9 bus readback after reset", brd, 0);
        bus_write(1, 16'h0F0F, brd);
        bus_write(2, 16'hC001, brd);
        bus_model[0] = 16'hBEEF; bus_model[1] = 16'h0F0F; bus_model[2] = 16'hC001;

        // R9 readback of previous word
        bus_write(1, 16'hFFFF, brd);
        check(brd == bus_model[1], "R9 bus readback dev1", brd, bus_model[1]);
        bus_model[1] = 16'hFFFF;
        bus_write(0, 16'h0001, brd);
        check(brd == bus_model[0], "R9 bus readback dev0", brd, bus_model[0]);
        bus_model[0] = 16'h0001;

        // R5 bus: idle toggles, then empty select returns old word
        held = bus_dout;
        for (int i = 0; i < W; i++) begin
            logic r;
            serial_bit(1'b1, ~i[0], r);
        end
        check(bus_dout == held, "R5 bus sdout held", bus_dout, held);
        check(bus_oe == '0, "R6 bus oe idle toggles", bus_oe, 0);
        bus_sel[2] = 1;
        wait_clk(3);
        sb.push_back('{N + 2, bus_model[2], cyc + 1, "R5"});
        bus_sel[2] = 0;
        wait_clk(10);

        check(sb.size() == 0, "R4 all strobes seen", sb.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule